// File: doc/BRIEF.md
# USB Low/Full-Speed Packet Receiver

This block takes the two data lines of a USB low-speed or full-speed link, sampled on every edge of an oversampling clock, and turns one packet into a stream of decoded data bits. Each sample is mapped to a line symbol (J, K or SE0), and a K seen on an idle line marks the start of a packet. All later sampling instants are fixed by that first K: half a bit period in, then one bit period apart. No clock recovery is done on later edges.

At each sampling instant the symbol is NRZI-decoded against the symbol taken at the previous instant. Stuffed zeros are dropped. A seventh consecutive one is reported on an error strobe, and the bit is still delivered. An SE0 ends bit collection. The packet closes when an SE0 sample is directly followed by a J sample. A speed input selects the bit period and the J/K polarity. Byte assembly, PID and CRC checks belong to the logic that follows this block.

Top module: `usb_fsls_rx`

## Requirements
- R1: With `low_speed` = 0 the lines decode as follows: (dp=1, dm=0) is J, (dp=0, dm=1) is K, and (0,0) is SE0.
- R2: With `low_speed` = 1, J and K swap: (dp=0, dm=1) is J and (dp=1, dm=0) is K. The bit period is LS_BIT samples instead of FS_BIT.
- R3: While idle, the first clock edge at which the lines decode to K starts a packet. `sop_pulse` is high for exactly the one cycle after that edge.
- R4: Data bit N (counting line symbols from the start of the packet, stuffed symbols included) is taken at the edge lying floor(W/2) + N·W edges after the start edge, where W is the active bit period. Its result is registered at that edge. Samples between these instants have no effect on any output.
- R5: A decoded bit is 0 when the sampled symbol differs from the symbol sampled at the previous instant, and 1 when it is the same. For bit 0, the previous symbol is J.
- R6: After six consecutive delivered ones, a decoded 0 is a stuff bit. It is not delivered, and the run count restarts at zero.
- R7: A decoded 1 that follows six consecutive ones is delivered with `stuff_err` high in the same cycle as its `bit_valid`. Reception continues.
- R8: An SE0 taken at a sampling instant ends data collection and delivers no bit. Later instants deliver no data bits.
- R9: `eop_pulse` is high for one cycle, registered at the first sampling instant where J is taken directly after an SE0 sample. Any other order (for example SE0, K, J) does not end the packet.
- R10: After `eop_pulse` the block is idle again, and the next K starts a new packet with fresh NRZI and run-count state.
- R11: Each delivered bit appears on `bit_data` with `bit_valid` high for one cycle, in line order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock; one line sample per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_speed | input | 1 | 1 selects low-speed period and polarity; held stable during a packet |
| dp | input | 1 | Sampled D+ line |
| dm | input | 1 | Sampled D- line |
| sop_pulse | output | 1 | One-cycle start-of-packet strobe |
| bit_valid | output | 1 | Qualifies `bit_data` for one cycle |
| bit_data | output | 1 | Decoded, unstuffed data bit |
| stuff_err | output | 1 | One-cycle flag on a seventh consecutive one |
| eop_pulse | output | 1 | One-cycle end-of-packet strobe |

## Verification
Every output is one register stage behind the edge that produced it. `sop_pulse` is therefore seen in the cycle numbered by the edge that first sampled K. Each bit, error flag and `eop_pulse` is seen in the cycle numbered by the start edge plus floor(W/2) plus its line-symbol index times W. The bench records the edge index at which it launches every packet. It logs each strobe with the edge count read at the falling clock edge, and compares those counts, not just the bit values, against the positions that its own encoder predicts. Random packets also carry a one-cycle glitch at the last sample of each symbol, which must never reach an output.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    typedef enum logic [1:0] {
        SYM_J   = 2'd0,
        SYM_K   = 2'd1,
        SYM_SE0 = 2'd2,
        SYM_SE1 = 2'd3
    } line_sym_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_EOP  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/usb_line_sym.sv
module usb_line_sym
    import usb_rx_pkg::*;
(
    input  logic      dp,
    input  logic      dm,
    input  logic      low_speed,
    output line_sym_e sym
);

    // Low-speed swaps the meaning of the two differential states.
    always_comb begin
        case ({dp, dm})
            2'b00:   sym = SYM_SE0;
            2'b10:   sym = low_speed ? SYM_K : SYM_J;
            2'b01:   sym = low_speed ? SYM_J : SYM_K;
            default: sym = SYM_SE1;
        endcase
    end

endmodule

// File: rtl/usb_mid_bit_timer.sv
module usb_mid_bit_timer #(
    parameter int FS_BIT = 4,
    parameter int LS_BIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_speed,
    input  logic start,
    input  logic run,
    output logic tick
);

    localparam int MAX_BIT = (FS_BIT > LS_BIT) ? FS_BIT : LS_BIT;
    localparam int CW      = $clog2(MAX_BIT);

    localparam logic [CW-1:0] FS_HALF_M1 = CW'(FS_BIT / 2 - 1);
    localparam logic [CW-1:0] LS_HALF_M1 = CW'(LS_BIT / 2 - 1);
    localparam logic [CW-1:0] FS_PER_M1  = CW'(FS_BIT - 1);
    localparam logic [CW-1:0] LS_PER_M1  = CW'(LS_BIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        tick = run && !start && (t_q.cnt == '0);
        if (start) begin
            // First instant lies half a bit after the start edge.
            t_d.cnt = low_speed ? LS_HALF_M1 : FS_HALF_M1;
        end else if (run) begin
            if (t_q.cnt == '0) t_d.cnt = low_speed ? LS_PER_M1 : FS_PER_M1;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/usb_nrzi_unstuff.sv
module usb_nrzi_unstuff
    import usb_rx_pkg::*;
#(
    parameter int RUN_LIMIT = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      sample_en,
    input  line_sym_e sym,
    output logic      emit,
    output logic      dbit,
    output logic      run_err
);

    localparam int            OW       = $clog2(RUN_LIMIT + 2);
    localparam logic [OW-1:0] RUN_AT   = OW'(RUN_LIMIT);
    localparam logic [OW-1:0] RUN_SAT  = OW'(RUN_LIMIT + 1);

    typedef struct packed {
        line_sym_e     prev;
        logic [OW-1:0] ones;
    } nrzi_t;

    nrzi_t n_d, n_q;
    logic  same;
    logic  at_limit;

    always_comb begin
        n_d      = n_q;
        same     = (sym == n_q.prev);
        at_limit = (n_q.ones == RUN_AT);
        dbit     = same;
        emit     = sample_en && !(at_limit && !same);
        run_err  = sample_en && same && at_limit;
        if (clear) begin
            n_d.prev = SYM_J;
            n_d.ones = '0;
        end else if (sample_en) begin
            n_d.prev = sym;
            if (!same)                n_d.ones = '0;
            else if (n_q.ones != RUN_SAT) n_d.ones = n_q.ones + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q.prev <= SYM_J;
            n_q.ones <= '0;
        end else begin
            n_q <= n_d;
        end
    end

endmodule

// File: rtl/usb_fsls_rx.sv
module usb_fsls_rx
    import usb_rx_pkg::*;
#(
    parameter int FS_BIT    = 4,
    parameter int LS_BIT    = 32,
    parameter int RUN_LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_speed,
    input  logic dp,
    input  logic dm,
    output logic sop_pulse,
    output logic bit_valid,
    output logic bit_data,
    output logic stuff_err,
    output logic eop_pulse
);

    typedef struct packed {
        rx_state_e st;
        logic      last_se0;
        logic      sop;
        logic      eop;
        logic      valid;
        logic      data;
        logic      err;
    } rx_t;

    rx_t       r_d, r_q;
    line_sym_e sym;
    logic      tick;
    logic      tmr_start;
    logic      bit_en;
    logic      emit;
    logic      dbit;
    logic      run_err;

    usb_line_sym u_sym (
        .dp        (dp),
        .dm        (dm),
        .low_speed (low_speed),
        .sym       (sym)
    );

    usb_mid_bit_timer #(
        .FS_BIT (FS_BIT),
        .LS_BIT (LS_BIT)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_speed (low_speed),
        .start     (tmr_start),
        .run       (r_q.st != ST_IDLE),
        .tick      (tick)
    );

    usb_nrzi_unstuff #(
        .RUN_LIMIT (RUN_LIMIT)
    ) u_nrzi (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (r_q.st == ST_IDLE),
        .sample_en (bit_en),
        .sym       (sym),
        .emit      (emit),
        .dbit      (dbit),
        .run_err   (run_err)
    );

    always_comb begin
        r_d       = r_q;
        r_d.sop   = 1'b0;
        r_d.eop   = 1'b0;
        tmr_start = 1'b0;
        bit_en    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (sym == SYM_K) begin
                    r_d.sop   = 1'b1;
                    r_d.st    = ST_BITS;
                    tmr_start = 1'b1;
                end
            end
            ST_BITS: begin
                if (tick) begin
                    if (sym == SYM_SE0) begin
                        r_d.st       = ST_EOP;
                        r_d.last_se0 = 1'b1;
                    end else begin
                        bit_en = 1'b1;
                    end
                end
            end
            ST_EOP: begin
                if (tick) begin
                    if (r_q.last_se0 && sym == SYM_J) begin
                        r_d.eop      = 1'b1;
                        r_d.st       = ST_IDLE;
                        r_d.last_se0 = 1'b0;
                    end else begin
                        r_d.last_se0 = (sym == SYM_SE0);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.valid = emit;
        r_d.data  = emit & dbit;
        r_d.err   = run_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.last_se0 <= 1'b0;
            r_q.sop      <= 1'b0;
            r_q.eop      <= 1'b0;
            r_q.valid    <= 1'b0;
            r_q.data     <= 1'b0;
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sop_pulse = r_q.sop;
    assign eop_pulse = r_q.eop;
    assign bit_valid = r_q.valid;
    assign bit_data  = r_q.data;
    assign stuff_err = r_q.err;

endmodule

// File: rtl/usb_fsls_rx_chk.sv
module usb_fsls_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic low_speed,
    input logic dp,
    input logic dm,
    input logic sop_pulse,
    input logic bit_valid,
    input logic bit_data,
    input logic stuff_err,
    input logic eop_pulse
);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sop_pulse, bit_valid, eop_pulse})); // R11

    AST_SOP_AFTER_K: assert property (@(posedge clk) disable iff (!rst_n)
        sop_pulse |-> ($past(low_speed) ? $past(dp && !dm) : $past(!dp && dm))); // R3

    AST_EOP_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> ($past(low_speed) ? $past(!dp && dm) : $past(dp && !dm))); // R9

    AST_NO_BIT_FROM_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(dp || dm)); // R8

    AST_ERR_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> (bit_valid && bit_data)); // R7

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid); // R11

    AST_SOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sop_pulse |=> !sop_pulse); // R3

endmodule

bind usb_fsls_rx usb_fsls_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .low_speed (low_speed),
    .dp        (dp),
    .dm        (dm),
    .sop_pulse (sop_pulse),
    .bit_valid (bit_valid),
    .bit_data  (bit_data),
    .stuff_err (stuff_err),
    .eop_pulse (eop_pulse)
);

// File: tb/usb_fsls_rx_bench.sv
`timescale 1ns/1ps
module usb_fsls_rx_bench;

    localparam int FS_BIT = 4;
    localparam int LS_BIT = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic low_speed = 1'b0;
    logic dp = 1'b1;
    logic dm = 1'b0;
    logic sop_pulse, bit_valid, bit_data, stuff_err, eop_pulse;

    always #2.5 clk = ~clk;

    usb_fsls_rx #(.FS_BIT(FS_BIT), .LS_BIT(LS_BIT), .RUN_LIMIT(6)) u_usb_fsls_rx (
        .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .dp(dp), .dm(dm),
        .sop_pulse(sop_pulse), .bit_valid(bit_valid), .bit_data(bit_data),
        .stuff_err(stuff_err), .eop_pulse(eop_pulse)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Monitor: log strobes with the edge count of the edge that made them.
    int got_bit[0:255], got_bcyc[0:255], nb;
    int sop_cyc, nsop, eop_cyc, neop;
    int err_cyc[0:31], nerr;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid && nb < 256) begin got_bit[nb] = bit_data; got_bcyc[nb] = cyc; nb++; end
            if (sop_pulse) begin sop_cyc = cyc; nsop++; end
            if (eop_pulse) begin eop_cyc = cyc; neop++; end
            if (stuff_err && nerr < 32) begin err_cyc[nerr] = cyc; nerr++; end
        end
    end

    // Expected stream: symbols 0=J 1=K 2=SE0
    int pay[0:127];
    int seq[0:255], nseq;
    int exp_bit[0:255], exp_sidx[0:255], nexp;
    int experr_sidx[0:31], nexperr;
    int eop_sidx;

    task automatic build(int nbits, bit stuff_en, bit eop_var);
        int prev = 0;
        int ones = 0;
        nseq = 0; nexp = 0; nexperr = 0;
        for (int i = 0; i < nbits; i++) begin
            int b = pay[i];
            int s = b ? prev : (prev == 0 ? 1 : 0);
            seq[nseq] = s;
            exp_bit[nexp] = b;
            exp_sidx[nexp] = nseq;
            if (b == 1 && ones == 6) begin experr_sidx[nexperr] = nseq; nexperr++; end
            nexp++; nseq++; prev = s;
            ones = b ? (ones < 7 ? ones + 1 : 7) : 0;
            if (stuff_en && ones == 6) begin
                prev = (prev == 0) ? 1 : 0;
                seq[nseq] = prev; nseq++;
                ones = 0;
            end
        end
        if (eop_var) begin
            seq[nseq] = 2; seq[nseq+1] = 1; seq[nseq+2] = 0;
            seq[nseq+3] = 2; seq[nseq+4] = 0; nseq += 5;
        end else begin
            seq[nseq] = 2; seq[nseq+1] = 2; seq[nseq+2] = 0; nseq += 3;
        end
        eop_sidx = nseq - 1;
    endtask

    task automatic put_sym(int s, bit ls);
        case (s)
            0:       begin dp = !ls; dm = ls;  end
            1:       begin dp = ls;  dm = !ls; end
            default: begin dp = 1'b0; dm = 1'b0; end
        endcase
    endtask

    task automatic idle(int n, bit ls);
        for (int i = 0; i < n; i++) begin @(negedge clk); low_speed = ls; put_sym(0, ls); end
    endtask

    task automatic run_pkt(string name, bit ls, bit glitch);
        int w = ls ? LS_BIT : FS_BIT;
        int h = w / 2;
        int e0 = 0;
        idle(4, ls);
        nb = 0; nsop = 0; neop = 0; nerr = 0;
        for (int k = 0; k < nseq; k++) begin
            for (int j = 0; j < w; j++) begin
                @(negedge clk);
                if (k == 0 && j == 0) e0 = cyc + 1;
                if (glitch && j == w - 1 && k < nseq - 1)
                    put_sym(seq[k] == 0 ? 1 : 0, ls);
                else
                    put_sym(seq[k], ls);
            end
        end
        idle(3 * w, ls);
        chk($sformatf("R3 sop count %s", name), nsop, 1);
        chk($sformatf("R3 sop cycle %s", name), sop_cyc, e0);
        chk($sformatf("R6 R8 bit count %s", name), nb, nexp);
        for (int i = 0; i < nexp && i < nb; i++) begin
            chk($sformatf("R5 R11 data bit %0d %s", i, name), got_bit[i], exp_bit[i]);
            chk($sformatf("R4 cycle bit %0d %s", i, name), got_bcyc[i], e0 + h + exp_sidx[i] * w);
        end
        chk($sformatf("R9 eop count %s", name), neop, 1);
        chk($sformatf("R9 eop cycle %s", name), eop_cyc, e0 + h + eop_sidx * w);
        chk($sformatf("R7 err count %s", name), nerr, nexperr);
        for (int i = 0; i < nexperr && i < nerr; i++)
            chk($sformatf("R7 err cycle %0d %s", i, name), err_cyc[i], e0 + h + experr_sidx[i] * w);
    endtask

    task automatic load_sync();
        for (int i = 0; i < 7; i++) pay[i] = 0;
        pay[7] = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        chk("reset sop", sop_pulse, 0);
        chk("reset valid", bit_valid, 0);
        chk("reset eop", eop_pulse, 0);
        chk("reset err", stuff_err, 0);
        rst_n = 1'b1;

        // R1 full-speed, with a run that forces a stuffed zero (R6)
        load_sync();
        for (int i = 8; i < 16; i++) pay[i] = 1;
        pay[16] = 0; pay[17] = 1; pay[18] = 0;
        build(19, 1'b1, 1'b0);
        run_pkt("R1 fs stuffed", 1'b0, 1'b0);

        // R2 low-speed polarity and period
        build(19, 1'b1, 1'b0);
        run_pkt("R2 ls stuffed", 1'b1, 1'b0);

        // R7 unstuffed seven-plus ones, followed back-to-back by a new packet (R10)
        load_sync();
        for (int i = 8; i < 16; i++) pay[i] = 1;
        pay[16] = 0; pay[17] = 0;
        build(18, 1'b0, 1'b0);
        run_pkt("R7 fs err", 1'b0, 1'b0);
        load_sync();
        pay[8] = 1; pay[9] = 0; pay[10] = 1;
        build(11, 1'b1, 1'b0);
        run_pkt("R10 fs next", 1'b0, 1'b0);

        // R9 SE0 K J does not close; SE0 J later does (R8 no bits)
        load_sync();
        pay[8] = 0; pay[9] = 1; pay[10] = 1;
        build(11, 1'b1, 1'b1);
        run_pkt("R9 fs eop order", 1'b0, 1'b0);
        build(11, 1'b1, 1'b1);
        run_pkt("R9 ls eop order", 1'b1, 1'b1);

        // Random packets, speeds and off-centre glitches (R4)
        for (int p = 0; p < 20; p++) begin
            int n = 1 + ($urandom % 40);
            bit ls = 1'($urandom % 2);
            bit gl = 1'($urandom % 2);
            load_sync();
            for (int i = 0; i < n; i++) pay[8 + i] = ($urandom % 3 == 0) ? 0 : 1;
            build(8 + n, 1'b1, 1'b0);
            run_pkt($sformatf("R4 random %0d", p), ls, gl);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule